// File: doc/BRIEF.md
# DS3 Line Loss-of-Signal Detector

This block watches the recovered DS3 line one bit period at a time and decides whether the line has gone quiet. It takes the positive and negative rail bits with a bit-rate enable. A bit period in which either rail is high counts as a mark. A long unbroken run of empty bit periods raises a framer loss-of-signal flag.

Once raised, the flag is released only after enough marks arrive within a fixed block of bit periods. This gives the detector hysteresis, so a marginal line does not make the alarm flicker. A loss indication from an external line receiver is brought in through a two-flop synchronizer. It is merged with the framer flag into a combined alarm, and it is also mirrored in a small status word that can be read.

Top module: `ds3_los_det`

## Requirements
- R1: A bit period is taken only in a clock cycle with `bit_en` high. That bit period is a mark when `rpos` or `rneg` is high, and a zero when both are low.
- R2: While the flag is clear, the 180th consecutive zero sets `framer_los` on the clock edge that takes that bit. The new value is visible in the following cycle.
- R3: A mark on either rail restarts the consecutive-zero count. After a mark, a further 180 zeros are needed to set the flag.
- R4: In cycles with `bit_en` low, `rpos` and `rneg` have no effect. No count advances and no count restarts.
- R5: Once set, `framer_los` stays high for as long as zeros continue, however long the run is. The zero counter holds at its limit and does not wrap.
- R6: Release is judged over blocks of 180 bit periods. The first block starts with the first bit after the flag is set. If a block holds at least 60 marks, `framer_los` clears on the edge that takes the block's last bit.
- R7: Blocks do not overlap. A block with 59 or fewer marks leaves the flag set. The next block starts with a mark count of zero.
- R8: `ext_los_in` passes through two flops. A rise of `ext_los_in` shows on `los_alarm` and `line_stat[0]` after two clock edges, and not after one.
- R9: `los_alarm` is high exactly when `framer_los` is high or the synchronized external indication is high.
- R10: `line_stat` bit 0 is the synchronized external indication and bit 1 is `framer_los`. Bits 7 to 2 read zero.
- R11: Synchronous reset `rst` clears both counters, the synchronizer and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-period enable |
| rpos | input | 1 | Positive rail bit |
| rneg | input | 1 | Negative rail bit |
| ext_los_in | input | 1 | External line-receiver loss indication, asynchronous |
| framer_los | output | 1 | Framer loss-of-signal flag |
| los_alarm | output | 1 | Combined loss alarm |
| line_stat | output | 8 | Status word: bit 0 external, bit 1 framer flag |

## Verification
The release of the framer flag can land in the same cycle as the synchronized external indication rising. If the merge were wrong, the combined alarm would then show a one-cycle gap. The bench provokes this by raising `ext_los_in` one bit before the end of a release block that holds 60 marks. It then requires `los_alarm` to stay high on every sample while `framer_los` drops. A second coincidence is a zero run that has reached its limit while a block boundary arrives. Here the bench requires that a release still wins on a block with 60 marks.

// File: rtl/ds3_los_pkg.sv
package ds3_los_pkg;

    localparam int ZERO_LIMIT_DEF = 180;
    localparam int BLOCK_LEN_DEF  = 180;
    localparam int ONES_MIN_DEF   = 60;
    localparam int STAT_W         = 8;
    localparam int STAT_EXT_BIT   = 0;
    localparam int STAT_LOS_BIT   = 1;

    typedef enum logic {
        LINE_OK   = 1'b0,
        LINE_LOST = 1'b1
    } los_state_t;

    typedef struct packed {
        logic valid;
        logic mark;
    } line_bit_t;

    function automatic line_bit_t take_bit(input logic en, input logic p, input logic n);
        line_bit_t b;
        b.valid = en;
        b.mark  = p | n;
        return b;
    endfunction

endpackage

// File: rtl/ds3_los_sync.sv
module ds3_los_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/ds3_los_zero_run.sv
module ds3_los_zero_run
    import ds3_los_pkg::*;
#(
    parameter int ZERO_LIMIT = ZERO_LIMIT_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  line_bit_t bit_in,
    input  logic      flag_set,
    input  logic      clr,
    output logic      limit_hit
);
    localparam int RUN_W = $clog2(ZERO_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ZERO_LIMIT);
    localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(ZERO_LIMIT - 1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (bit_in.valid) begin
            if (bit_in.mark)         run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assign limit_hit = bit_in.valid && !bit_in.mark && !flag_set && (run_q == RUN_PRE);
endmodule

// File: rtl/ds3_los_density.sv
module ds3_los_density
    import ds3_los_pkg::*;
#(
    parameter int BLOCK_LEN = BLOCK_LEN_DEF,
    parameter int ONES_MIN  = ONES_MIN_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  line_bit_t bit_in,
    input  logic      active,
    output logic      release_hit
);
    localparam int POS_W  = $clog2(BLOCK_LEN);
    localparam int ONES_W = $clog2(BLOCK_LEN + 1);
    localparam logic [POS_W-1:0]  POS_LAST = POS_W'(BLOCK_LEN - 1);
    localparam logic [ONES_W-1:0] ONES_THR = ONES_W'(ONES_MIN);

    logic [POS_W-1:0]  pos_q;
    logic [ONES_W-1:0] ones_q;
    logic [ONES_W-1:0] ones_nx;
    logic              last_bit;

    assign ones_nx  = ones_q + {{(ONES_W-1){1'b0}}, bit_in.mark};
    assign last_bit = active && bit_in.valid && (pos_q == POS_LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pos_q  <= '0;
            ones_q <= '0;
        end else if (bit_in.valid) begin
            if (pos_q == POS_LAST) begin
                pos_q  <= '0;
                ones_q <= '0;
            end else begin
                pos_q  <= pos_q + 1'b1;
                ones_q <= ones_nx;
            end
        end
    end

    assign release_hit = last_bit && (ones_nx >= ONES_THR);
endmodule

// File: rtl/ds3_los_det.sv
module ds3_los_det
    import ds3_los_pkg::*;
#(
    parameter int ZERO_LIMIT = ZERO_LIMIT_DEF,
    parameter int BLOCK_LEN  = BLOCK_LEN_DEF,
    parameter int ONES_MIN   = ONES_MIN_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rpos,
    input  logic              rneg,
    input  logic              ext_los_in,
    output logic              framer_los,
    output logic              los_alarm,
    output logic [STAT_W-1:0] line_stat
);
    line_bit_t  cur_bit;
    los_state_t state_q;
    logic       set_hit;
    logic       rel_hit;
    logic       ext_sync;
    logic       lost;

    assign cur_bit = take_bit(bit_en, rpos, rneg);
    assign lost    = (state_q == LINE_LOST);

    ds3_los_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (ext_los_in),
        .q_out (ext_sync)
    );

    ds3_los_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) zrun_i (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (cur_bit),
        .flag_set  (lost),
        .clr       (rel_hit),
        .limit_hit (set_hit)
    );

    ds3_los_density #(.BLOCK_LEN(BLOCK_LEN), .ONES_MIN(ONES_MIN)) dens_i (
        .clk         (clk),
        .rst         (rst),
        .bit_in      (cur_bit),
        .active      (lost),
        .release_hit (rel_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)          state_q <= LINE_OK;
        else if (set_hit) state_q <= LINE_LOST;
        else if (rel_hit) state_q <= LINE_OK;
    end

    assign framer_los = lost;
    assign los_alarm  = lost | ext_sync;

    always_comb begin
        line_stat               = '0;
        line_stat[STAT_EXT_BIT] = ext_sync;
        line_stat[STAT_LOS_BIT] = lost;
    end
endmodule

// File: rtl/ds3_los_det_chk.sv
module ds3_los_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       rpos,
    input logic       rneg,
    input logic       framer_los,
    input logic       los_alarm,
    input logic [7:0] line_stat
);
    // R2: the flag rises only after a taken zero bit
    a_r2_set_on_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(framer_los) |-> $past(bit_en && !rpos && !rneg));

    // R3: a taken mark never sets the flag
    a_r3_mark_no_set: assert property (@(posedge clk) disable iff (rst)
        ($past(bit_en && (rpos || rneg)) && !$past(rst)) |-> !$rose(framer_los));

    // R4: without a bit period the flag holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(bit_en) && !$past(rst)) |-> $stable(framer_los));

    // R9: alarm is the OR of both sources
    a_r9_alarm_or: assert property (@(posedge clk) disable iff (rst)
        los_alarm == (framer_los || line_stat[0]));

    // R10: status mirrors the flag, upper bits zero
    a_r10_stat_map: assert property (@(posedge clk) disable iff (rst)
        (line_stat[1] == framer_los) && (line_stat[7:2] == 6'd0));

    // R11: the flag is clear after a reset cycle
    a_r11_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !framer_los);
endmodule

bind ds3_los_det ds3_los_det_chk chk_i (.*);

// File: tb/ds3_los_det_tb.sv
module ds3_los_det_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rpos = 1'b0;
    logic       rneg = 1'b0;
    logic       ext_los_in = 1'b0;
    logic       framer_los;
    logic       los_alarm;
    logic [7:0] line_stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ds3_los_det dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rpos(rpos), .rneg(rneg),
        .ext_los_in(ext_los_in), .framer_los(framer_los),
        .los_alarm(los_alarm), .line_stat(line_stat)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; rpos = 1'b0; rneg = 1'b0; ext_los_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put_bit(input logic p, input logic n);
        rpos = p; rneg = n; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; rpos = 1'b0; rneg = 1'b0;
    endtask

    task automatic zeros(input int cnt);
        for (int i = 0; i < cnt; i++) put_bit(1'b0, 1'b0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11 reset framer_los", framer_los, 0);
        check("R11 reset alarm", los_alarm, 0);
        check("R10 reset line_stat", line_stat, 0);
    endtask

    task automatic t_declare();
        do_reset();
        zeros(179);
        check("R2 179 zeros no flag", framer_los, 0);
        zeros(1);
        check("R2 180th zero sets flag", framer_los, 1);
        check("R9 alarm follows flag", los_alarm, 1);
        check("R10 stat bit1", line_stat, 2);
    endtask

    task automatic t_restart();
        do_reset();
        zeros(100);
        put_bit(1'b0, 1'b1);
        zeros(179);
        check("R3 neg-rail mark restarts run", framer_los, 0);
        put_bit(1'b1, 1'b0);
        zeros(179);
        check("R1 pos-rail mark restarts run", framer_los, 0);
        zeros(1);
        check("R3 180 zeros after mark set", framer_los, 1);
    endtask

    task automatic t_idle();
        do_reset();
        zeros(179);
        rpos = 1'b1; rneg = 1'b1;
        repeat (300) @(negedge clk);
        rpos = 1'b0; rneg = 1'b0;
        check("R4 idle marks ignored", framer_los, 0);
        zeros(1);
        check("R4 run kept through idle", framer_los, 1);
    endtask

    task automatic t_hold();
        do_reset();
        zeros(180);
        zeros(600);
        check("R5 flag held over long run", framer_los, 1);
    endtask

    task automatic t_release();
        do_reset();
        zeros(180);
        for (int i = 0; i < 179; i++) put_bit(i % 3 == 0, 1'b0);
        check("R6 no release before block end", framer_los, 1);
        put_bit(1'b0, 1'b0);
        check("R6 release on 60 ones", framer_los, 0);
        zeros(179);
        check("R6 run restarts after release", framer_los, 0);
        zeros(1);
        check("R6 re-declare after release", framer_los, 1);
    endtask

    task automatic t_block();
        do_reset();
        zeros(180);
        for (int i = 0; i < 180; i++) put_bit(1'b0, (i % 3 == 0) && (i < 177));
        check("R7 59 ones keep flag", framer_los, 1);
        for (int i = 0; i < 179; i++) put_bit(i % 3 == 0, 1'b0);
        check("R7 second block not early", framer_los, 1);
        put_bit(1'b0, 1'b0);
        check("R7 second block releases", framer_los, 0);
    endtask

    task automatic t_ext();
        do_reset();
        ext_los_in = 1'b1;
        @(negedge clk);
        check("R8 one edge not yet", los_alarm, 0);
        @(negedge clk);
        check("R8 two edges alarm", los_alarm, 1);
        check("R10 stat bit0", line_stat, 1);
        check("R9 framer unaffected", framer_los, 0);
        ext_los_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 alarm drops", los_alarm, 0);
    endtask

    task automatic t_coincide();
        int gaps = 0;
        do_reset();
        zeros(180);
        for (int i = 0; i < 180; i++) begin
            if (i == 178) ext_los_in = 1'b1;
            put_bit(i % 3 == 0, 1'b0);
            if (!los_alarm) gaps++;
        end
        check("R6 release under ext", framer_los, 0);
        check("R9 alarm no gap", gaps, 0);
        check("R9 alarm held by ext", los_alarm, 1);
    endtask

    task automatic t_mid_reset();
        do_reset();
        zeros(180);
        do_reset();
        check("R11 reset clears flag", framer_los, 0);
        zeros(179);
        check("R11 reset clears run", framer_los, 0);
    endtask

    initial begin
        t_reset_state();
        t_declare();
        t_restart();
        t_idle();
        t_hold();
        t_release();
        t_block();
        t_ext();
        t_coincide();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule